// File: doc/BRIEF.md
# Dual-Prescaler PWM Generator with Interrupt

This block produces one pulse width modulated output from the system clock. The clock first passes a power-of-two divider and then a linear divider. Each output pulse of the second divider advances a period counter. The output is active while the counter is below the duty value, and its level can be inverted. A status flag marks the end of every PWM cycle and can raise a level interrupt.

Software drives the block through a plain register port: a write strobe, an address, write data and a combinational read-data bus. Duty and period writes are staged: a running cycle always completes with the values it started with. When the block is disabled, both dividers and the counter are held at zero and the output rests at its inactive level.

Top module: `pwm_dualdiv`

Register map (word addresses on `reg_addr_i`): 0 = CTRL (bit 0 run, bit 1 invert, bit 2 interrupt enable), 1 = DIV (bits 2:0 power-of-two select, bits 12:8 linear select), 2 = DUTY, 3 = PERIOD, 4 = STATUS (bit 0 end-of-cycle flag, write 1 to clear).

## Requirements
- R1: After reset, `pwm_o` and `irq_o` are low, and every register at addresses 0 to 4 reads as zero.
- R2: The first divider stage divides the clock by 2 to the power of DIV[2:0], so the values 0 to 7 give division by 1 up to 128.
- R3: The second divider stage divides the first stage's output by DIV[12:8]+1. The period counter therefore advances once every 2^DIV[2:0]*(DIV[12:8]+1) clocks, with the first advance that many clocks after the enabling write.
- R4: With invert clear, one PWM cycle lasts PERIOD counter steps, and a PERIOD of 0 counts as 1. The output is high while the count is below DUTY. A DUTY of PERIOD or more keeps the output high for the whole cycle, and a DUTY of 0 keeps it low.
- R5: When CTRL[1] is set, `pwm_o` is the inverse of the R4 waveform, so the duty count sets the low time.
- R6: While CTRL[0] is clear, both dividers and the period counter are held at zero and `pwm_o` equals CTRL[1]. Setting CTRL[0] again restarts the waveform from count zero.
- R7: STATUS[0] becomes 1 on the clock edge where the counter steps from the last count of a cycle back to zero. It then stays at 1 until it is cleared.
- R8: `irq_o` is high exactly when STATUS[0] and CTRL[2] are both 1.
- R9: Writing STATUS with bit 0 set clears the flag, and writing it with bit 0 clear has no effect. If a set event falls on the same edge as a clearing write, the flag stays 1.
- R10: Writes to DUTY and PERIOD while the block runs take effect only from the first count of the next PWM cycle.
- R11: Each register reads back the fields last written to it: CTRL bits 2:0, DIV bits 2:0 and 12:8, DUTY and PERIOD in their low CNT_W bits, and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 3 | Register address for both write and read |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data of the addressed register (combinational) |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bound checker checks several properties on every cycle:
- a disabled block shows the inactive level and clears its counter;
- the counter never passes the last index of the staged period;
- the flag sets, holds, clears and obeys set-wins priority;
- the interrupt is never raised without the flag.

The divide ratios of both stages, the duty compare against the period, the inversion, the staging of duty and period writes and the register readback depend on multi-cycle timing and programmed values. Only the bench's scenarios can show these, by comparing the output cycle by cycle against a closed-form expected waveform.

// File: rtl/pwm_dualdiv_pkg.sv
package pwm_dualdiv_pkg;

   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_CTRL   = 3'd0,
      REG_DIV    = 3'd1,
      REG_DUTY   = 3'd2,
      REG_PERIOD = 3'd3,
      REG_STATUS = 3'd4
   } reg_sel_e;

   localparam int unsigned CTRL_RUN_BIT  = 0;
   localparam int unsigned CTRL_INV_BIT  = 1;
   localparam int unsigned CTRL_IEN_BIT  = 2;
   localparam int unsigned DIV_LIN_LSB   = 8;
   localparam int unsigned STAT_FLAG_BIT = 0;

   typedef struct packed {
      logic irq_en;
      logic invert;
      logic run;
   } ctrl_t;

endpackage

// File: rtl/pwm_dd_regs.sv
module pwm_dd_regs
   import pwm_dualdiv_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned POW_W  = 3,
   parameter int unsigned LIN_W  = 5,
   localparam int unsigned POW_SW = (POW_W > 0) ? POW_W : 1,
   localparam int unsigned LIN_SW = (LIN_W > 0) ? LIN_W : 1
)(
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          we_i,
   input  logic [REG_ADDR_W-1:0]         addr_i,
   input  logic [DATA_W-1:0]             wdata_i,
   output logic [DATA_W-1:0]             rdata_o,
   input  logic                          set_evt_i,
   output ctrl_t                         ctrl_o,
   output logic [POW_SW-1:0]             pow_sel_o,
   output logic [LIN_SW-1:0]             lin_sel_o,
   output logic [CNT_W-1:0]              duty_o,
   output logic [CNT_W-1:0]              period_o,
   output logic                          flag_o
);

   ctrl_t              ctrl_q;
   logic [POW_SW-1:0]  pow_q;
   logic [LIN_SW-1:0]  lin_q;
   logic [CNT_W-1:0]   duty_q;
   logic [CNT_W-1:0]   per_q;
   logic               flag_q;

   logic wr_ctrl, wr_div, wr_duty, wr_per, wr_stat;

   assign wr_ctrl = we_i && (addr_i == REG_CTRL);
   assign wr_div  = we_i && (addr_i == REG_DIV);
   assign wr_duty = we_i && (addr_i == REG_DUTY);
   assign wr_per  = we_i && (addr_i == REG_PERIOD);
   assign wr_stat = we_i && (addr_i == REG_STATUS);

   logic [POW_SW-1:0] pow_wr;
   logic [LIN_SW-1:0] lin_wr;

   generate
      if (POW_W > 0) begin : g_pow_field
         assign pow_wr = wdata_i[POW_SW-1:0];
      end else begin : g_pow_none
         assign pow_wr = '0;
      end
      if (LIN_W > 0) begin : g_lin_field
         assign lin_wr = wdata_i[DIV_LIN_LSB +: LIN_SW];
      end else begin : g_lin_none
         assign lin_wr = '0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         pow_q  <= '0;
         lin_q  <= '0;
         duty_q <= '0;
         per_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.run    <= wdata_i[CTRL_RUN_BIT];
            ctrl_q.invert <= wdata_i[CTRL_INV_BIT];
            ctrl_q.irq_en <= wdata_i[CTRL_IEN_BIT];
         end
         if (wr_div) begin
            pow_q <= pow_wr;
            lin_q <= lin_wr;
         end
         if (wr_duty) duty_q <= wdata_i[CNT_W-1:0];
         if (wr_per)  per_q  <= wdata_i[CNT_W-1:0];
         // set event has priority over a clearing write
         if (set_evt_i) begin
            flag_q <= 1'b1;
         end else if (wr_stat && wdata_i[STAT_FLAG_BIT]) begin
            flag_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         REG_CTRL: begin
            rdata_o[CTRL_RUN_BIT] = ctrl_q.run;
            rdata_o[CTRL_INV_BIT] = ctrl_q.invert;
            rdata_o[CTRL_IEN_BIT] = ctrl_q.irq_en;
         end
         REG_DIV: begin
            rdata_o[POW_SW-1:0]             = pow_q;
            rdata_o[DIV_LIN_LSB +: LIN_SW]  = lin_q;
         end
         REG_DUTY:   rdata_o[CNT_W-1:0]    = duty_q;
         REG_PERIOD: rdata_o[CNT_W-1:0]    = per_q;
         REG_STATUS: rdata_o[STAT_FLAG_BIT] = flag_q;
         default: ;
      endcase
   end

   assign ctrl_o    = ctrl_q;
   assign pow_sel_o = pow_q;
   assign lin_sel_o = lin_q;
   assign duty_o    = duty_q;
   assign period_o  = per_q;
   assign flag_o    = flag_q;

endmodule

// File: rtl/pwm_dd_prescale.sv
module pwm_dd_prescale #(
   parameter int unsigned POW_W = 3,
   parameter int unsigned LIN_W = 5,
   localparam int unsigned POW_SW = (POW_W > 0) ? POW_W : 1,
   localparam int unsigned LIN_SW = (LIN_W > 0) ? LIN_W : 1,
   localparam int unsigned P1_W   = (POW_W > 0) ? ((1 << POW_W) - 1) : 1
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [POW_SW-1:0] pow_sel_i,
   input  logic [LIN_SW-1:0] lin_sel_i,
   output logic              tick_o
);

   logic tick1;

   generate
      if (POW_W > 0) begin : g_pow
         logic [P1_W-1:0] c1_q;
         logic [P1_W-1:0] limit1;
         // all-ones below the selected bit position; wraps to all-ones at the top select
         assign limit1 = (P1_W'(1) << pow_sel_i) - P1_W'(1);
         assign tick1  = run_i && (c1_q == limit1);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     c1_q <= '0;
            else if (!run_i) c1_q <= '0;
            else if (tick1)  c1_q <= '0;
            else             c1_q <= c1_q + P1_W'(1);
         end
      end else begin : g_nopow
         logic unused_pow;
         assign unused_pow = ^pow_sel_i;
         assign tick1      = run_i;
      end

      if (LIN_W > 0) begin : g_lin
         logic [LIN_SW-1:0] c2_q;
         logic              tick2;
         assign tick2 = tick1 && (c2_q == lin_sel_i);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     c2_q <= '0;
            else if (!run_i) c2_q <= '0;
            else if (tick2)  c2_q <= '0;
            else if (tick1)  c2_q <= c2_q + LIN_SW'(1);
         end
         assign tick_o = tick2;
      end else begin : g_nolin
         logic unused_lin;
         assign unused_lin = ^lin_sel_i;
         assign tick_o     = tick1;
      end
   endgenerate

endmodule

// File: rtl/pwm_dd_core.sv
module pwm_dd_core #(
   parameter int unsigned CNT_W = 16
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             invert_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             pwm_o,
   output logic             cycle_end_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] last_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] duty_sh_q;
   logic [CNT_W-1:0] per_sh_q;
   logic [CNT_W-1:0] last_idx;
   logic             at_end;
   logic             active;

   // a staged period of zero behaves as a one-step cycle
   assign last_idx = (per_sh_q == '0) ? '0 : (per_sh_q - CNT_W'(1));
   assign at_end   = run_i && tick_i && (cnt_q == last_idx);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q     <= '0;
         duty_sh_q <= '0;
         per_sh_q  <= '0;
      end else if (!run_i || at_end) begin
         cnt_q     <= '0;
         duty_sh_q <= duty_i;
         per_sh_q  <= period_i;
      end else if (tick_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign active      = run_i && (cnt_q < duty_sh_q);
   assign pwm_o       = active ^ invert_i;
   assign cycle_end_o = at_end;
   assign cnt_o       = cnt_q;
   assign last_o      = last_idx;

endmodule

// File: rtl/pwm_dualdiv.sv
module pwm_dualdiv
   import pwm_dualdiv_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned POW_W  = 3,
   parameter int unsigned LIN_W  = 5
)(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  reg_we_i,
   input  logic [2:0]            reg_addr_i,
   input  logic [DATA_W-1:0]     reg_wdata_i,
   output logic [DATA_W-1:0]     reg_rdata_o,
   output logic                  pwm_o,
   output logic                  irq_o
);

   localparam int unsigned POW_SW = (POW_W > 0) ? POW_W : 1;
   localparam int unsigned LIN_SW = (LIN_W > 0) ? LIN_W : 1;

   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_chk_cnt
         $error("CNT_W must lie between 1 and DATA_W");
      end
      if (POW_W > 5) begin : g_chk_pow
         $error("POW_W above 5 makes the first divider too wide");
      end
      if (POW_W > DIV_LIN_LSB) begin : g_chk_pow_fit
         $error("POW_W overlaps the linear select field");
      end
      if (DIV_LIN_LSB + LIN_SW > DATA_W) begin : g_chk_lin
         $error("linear select field does not fit DATA_W");
      end
      if (DATA_W < 3) begin : g_chk_data
         $error("DATA_W too narrow for the control bits");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [POW_SW-1:0] pow_sel;
   logic [LIN_SW-1:0] lin_sel;
   logic [CNT_W-1:0]  duty;
   logic [CNT_W-1:0]  period;
   logic              flag;
   logic              tick;
   logic              cycle_end;
   logic [CNT_W-1:0]  core_cnt;
   logic [CNT_W-1:0]  core_last;

   pwm_dd_regs #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .POW_W  (POW_W),
      .LIN_W  (LIN_W)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (reg_we_i),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .rdata_o   (reg_rdata_o),
      .set_evt_i (cycle_end),
      .ctrl_o    (ctrl),
      .pow_sel_o (pow_sel),
      .lin_sel_o (lin_sel),
      .duty_o    (duty),
      .period_o  (period),
      .flag_o    (flag)
   );

   pwm_dd_prescale #(
      .POW_W (POW_W),
      .LIN_W (LIN_W)
   ) u_presc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (ctrl.run),
      .pow_sel_i (pow_sel),
      .lin_sel_i (lin_sel),
      .tick_o    (tick)
   );

   pwm_dd_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (ctrl.run),
      .invert_i    (ctrl.invert),
      .tick_i      (tick),
      .duty_i      (duty),
      .period_i    (period),
      .pwm_o       (pwm_o),
      .cycle_end_o (cycle_end),
      .cnt_o       (core_cnt),
      .last_o      (core_last)
   );

   assign irq_o = flag & ctrl.irq_en;

endmodule

// File: rtl/pwm_dualdiv_chk.sv
module pwm_dualdiv_chk #(
   parameter int unsigned CNT_W = 16
)(
   input logic             clk_i,
   input logic             rst_ni,
   input logic             reg_we_i,
   input logic [2:0]       reg_addr_i,
   input logic             clr_bit_i,
   input logic             run_i,
   input logic             invert_i,
   input logic             irq_en_i,
   input logic             flag_i,
   input logic             set_evt_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic [CNT_W-1:0] last_i,
   input logic             pwm_i,
   input logic             irq_i
);

   logic clear_wr;
   assign clear_wr = reg_we_i && (reg_addr_i == 3'd4) && clr_bit_i;

   // R6: disabled output sits at the inactive level
   a_r6_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |-> (pwm_i == invert_i));

   // R6: counter is cleared while disabled
   a_r6_counter_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (cnt_i == '0));

   // R4: counter never passes the last index of the staged period
   a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i <= last_i);

   // R7: end of cycle sets the flag
   a_r7_set_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_evt_i |=> flag_i);

   // R7: flag holds until cleared
   a_r7_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i && !clear_wr) |=> flag_i);

   // R7: flag never rises without an event
   a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_i && !set_evt_i) |=> !flag_i);

   // R9: a clearing write without a coincident event clears the flag
   a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clear_wr && !set_evt_i) |=> !flag_i);

   // R8: interrupt only with the flag set and enabled
   a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i |-> (flag_i && irq_en_i));

endmodule

bind pwm_dualdiv pwm_dualdiv_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .reg_we_i   (reg_we_i),
   .reg_addr_i (reg_addr_i),
   .clr_bit_i  (reg_wdata_i[0]),
   .run_i      (ctrl.run),
   .invert_i   (ctrl.invert),
   .irq_en_i   (ctrl.irq_en),
   .flag_i     (flag),
   .set_evt_i  (cycle_end),
   .cnt_i      (core_cnt),
   .last_i     (core_last),
   .pwm_i      (pwm_o),
   .irq_i      (irq_o)
);

// File: tb/test_pwm_dualdiv.sv
module test_pwm_dualdiv;

   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          pwm;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #4ns clk = ~clk;

   pwm_dualdiv i_pwm_dualdiv (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .reg_we_i    (reg_we),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .pwm_o       (pwm),
      .irq_o       (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1ns;
      d = reg_rdata;
   endtask

   // expected output level after n clocks since the enabling edge
   function automatic bit exp_level(int n, int d, int pe, int duty, bit inv);
      return inv ^ (((n / d) % pe) < duty);
   endfunction

   task automatic run_case(input int p, input int l, input int per, input int duty,
                           input bit inv, input bit ien, input string tag);
      int d, pe, ncyc;
      logic [31:0] v;
      d    = (1 << p) * (l + 1);
      pe   = (per == 0) ? 1 : per;
      ncyc = 2 * pe * d + 3;
      wr(3'd1, (l << 8) | p);
      wr(3'd3, per);
      wr(3'd2, duty);
      wr(3'd0, {29'd0, ien, inv, 1'b1});
      for (int n = 0; n < ncyc; n++) begin
         rd(3'd4, v);
         chk(inv ? "R5 level" : tag, pwm, exp_level(n, d, pe, duty, inv));
         chk("R7 flag", v[0], (n >= pe * d));
         chk("R8 irq", irq, (n >= pe * d) && ien);
         @(negedge clk);
      end
      wr(3'd0, {29'd0, ien, inv, 1'b0});
      repeat (3) @(negedge clk);
      #1ns;
      chk("R6 idle", pwm, inv);
      wr(3'd4, 32'd1);
      rd(3'd4, v);
      chk("R9 clear", v[0], 1'b0);
   endtask

   initial begin
      logic [31:0] v;
      bit  exp_flag;
      int  ecnt, eduty;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 pwm", pwm, 1'b0);
      chk("R1 irq", irq, 1'b0);
      for (int a = 0; a < 5; a++) begin
         rd(a[2:0], v);
         chk("R1 reg", v, 32'd0);
      end

      // R11: readback of fields, unused bits zero
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd1, v);
      chk("R11 div", v, 32'h0000_1F07);
      wr(3'd1, (32'd17 << 8) | 32'd5);
      rd(3'd1, v);
      chk("R11 div", v, 32'h0000_1105);
      wr(3'd0, 32'hFFFF_FFF6);
      rd(3'd0, v);
      chk("R11 ctrl", v, 32'd6);
      wr(3'd0, 32'd0);
      wr(3'd2, 32'hABCD_1234);
      rd(3'd2, v);
      chk("R11 duty", v, 32'h0000_1234);

      // directed corner cases
      run_case(0, 0, 4, 0, 1'b0, 1'b1, "R4 duty zero");
      run_case(0, 0, 4, 9, 1'b0, 1'b0, "R4 duty full");
      run_case(0, 0, 0, 1, 1'b1, 1'b1, "R4 period zero");
      run_case(0, 5, 3, 2, 1'b0, 1'b1, "R3 linear");
      run_case(3, 0, 3, 1, 1'b0, 1'b0, "R2 pow");
      run_case(7, 31, 2, 1, 1'b0, 1'b1, "R2 max div");

      // constrained random
      for (int k = 0; k < 10; k++) begin
         run_case($urandom % 3, $urandom % 4, $urandom % 9, $urandom % 11,
                  1'($urandom % 2), 1'($urandom % 2), "R4 random");
      end

      // R10 staging, R9 set-wins and write-zero, D=1, P=4, duty=1
      wr(3'd1, 32'd0);
      wr(3'd3, 32'd4);
      wr(3'd2, 32'd1);
      wr(3'd0, 32'd5);
      for (int n = 0; n < 21; n++) begin
         reg_we = 1'b0;
         rd(3'd4, v);
         ecnt  = (n < 16) ? (n % 4) : ((n - 16) % 2);
         eduty = (n < 8) ? 1 : 3;
         if (n < 4)       exp_flag = 1'b0;
         else if (n < 10) exp_flag = 1'b1;
         else if (n < 12) exp_flag = 1'b0;
         else             exp_flag = 1'b1;
         chk("R10 staged", pwm, (ecnt < eduty));
         chk((n == 8) ? "R9 set wins" : "R9 flag", v[0], exp_flag);
         chk("R8 irq", irq, exp_flag);
         if (n == 5)  begin reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'd3; end
         if (n == 7)  begin reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'd1; end
         if (n == 9)  begin reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'd1; end
         if (n == 13) begin reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'd0; end
         if (n == 14) begin reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd2; end
         @(negedge clk);
      end
      reg_we = 1'b0;
      rd(3'd2, v);
      chk("R11 duty", v, 32'd3);
      wr(3'd0, 32'd0);
      #1ns;
      chk("R6 idle", pwm, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule